// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Slave

This block is the configuration port of a clock generator. It watches a two-wire serial bus, made of a clock line and an open-drain data line, and accepts block-write transactions from a bus host. The decoded data land in a bank of byte-wide configuration registers, which are presented as one flat parallel output. Both bus lines are brought into the system clock domain through two-flop synchronizers. All edge, START and STOP detection then runs on the synchronized copies.

A transaction opens with a START condition. The first byte is an address. The second and third bytes are command and count fields that the block acknowledges and throws away. After those come the data bytes, which fill registers 0, 1, 2 and so on in order. Each data byte is committed the moment its eighth bit is sampled, so a transfer that is cut short keeps every byte that arrived complete. The bus only writes: nothing can be read back. After a power-on reset every register holds its default value, so the clock generator works even if the bus is never used.

Top module: `cfg_serial_slave`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first write, `cfg_o` equals the parameter `DEFAULTS` (default value 64'h00FF0F5A00000381). Register k is `cfg_o[8k+7:8k]`.
- R2: A START is `sda_i` falling while `scl_i` is high. A STOP is `sda_i` rising while `scl_i` is high. Bits are sampled on rising `scl_i` edges, most significant bit first, with nine clocks per byte. The ninth clock is the acknowledge slot.
- R3: The first byte after a START is accepted only when it equals `ADDR` (8'hD2), including its least significant bit. On a match the block pulls the data line low (`sda_pull_o` = 1) for the ninth clock of that byte.
- R4: A mismatched address gets no acknowledge. No register changes, and every later bit is ignored until the next START.
- R5: The two bytes after an accepted address are acknowledged and discarded whatever their values. They still count as bytes in the sequence.
- R6: Data byte k (byte position k+4 counted from 1) is written into register k when its eighth bit is sampled. It is acknowledged on its ninth clock.
- R7: A STOP or a repeated START at any point ends the transaction. Bytes already committed stay. A partly shifted byte is dropped. A new START expects an address byte again.
- R8: Bytes sent after the last data byte are not acknowledged and change no register.
- R9: `sda_pull_o` only switches on while the synchronized `scl_i` is low, and it is released on the falling clock that ends the acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_pull_o | output | 1 | When 1, the open-drain driver pulls the data line low |
| cfg_o | output | 8*NREG | Flat configuration register bank, register k in bits 8k+7:8k |

## Verification
The bench builds the block with its default parameters: eight registers, two discarded header bytes and address 8'hD2. With these values every byte position can be reached within one transaction, including the one just past the last data byte, which lets the bench check R8. It runs the address check both against a neighbouring value and against the matching address with the read bit set. It also cuts transactions short after whole bytes and in the middle of a byte, and restarts them with a repeated START. A behavioural model written bit by bit predicts the register bank and the acknowledge line, and the bench compares them with the design on every settled clock.

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int NREG = 8,
  parameter int SKIP = 2,
  parameter logic [7:0] ADDR = 8'hD2,
  parameter logic [8*NREG-1:0] DEFAULTS = 64'h00FF0F5A00000381
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_pull_o,
  output logic [8*NREG-1:0] cfg_o
);
  localparam int IW = $clog2(SKIP + NREG + 2);
  localparam logic [IW-1:0] FIRST_I = IW'(SKIP + 1);
  localparam logic [IW-1:0] LAST_I  = IW'(SKIP + NREG);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RUN = 2'd1, S_SKIP = 2'd2} st_t;

  logic [2:0] scl_p, sda_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  assign scl_s    = scl_p[1];
  assign sda_s    = sda_p[1];
  assign scl_rise = scl_s & ~scl_p[2];
  assign scl_fall = ~scl_s & scl_p[2];
  assign start_c  = scl_s & scl_p[2] & ~sda_s & sda_p[2];
  assign stop_c   = scl_s & scl_p[2] & sda_s & ~sda_p[2];

  st_t st;
  logic [3:0] bitcnt;
  logic [IW-1:0] idx;
  logic [7:0] shreg;
  logic ack_q;
  logic [7:0] nxt;
  assign nxt = {shreg[6:0], sda_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      bitcnt <= '0;
      idx <= '0;
      shreg <= '0;
      ack_q <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (start_c) begin
      st <= S_RUN;
      bitcnt <= '0;
      idx <= '0;
      sda_pull_o <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE;
      sda_pull_o <= 1'b0;
    end else if (st == S_RUN) begin
      if (scl_rise) begin
        if (bitcnt != 4'd8) begin
          shreg <= nxt;
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7)
            ack_q <= (idx == '0) ? (nxt == ADDR) : (idx <= LAST_I);
        end else begin
          bitcnt <= '0;
          if (ack_q) idx <= idx + 1'b1;
          else       st <= S_SKIP;
        end
      end
      if (scl_fall) begin
        if (bitcnt == 4'd8 && ack_q) sda_pull_o <= 1'b1;
        else if (bitcnt == 4'd0)     sda_pull_o <= 1'b0;
      end
    end else if (scl_fall) begin
      sda_pull_o <= 1'b0;
    end

  logic wr_en;
  logic [IW-1:0] wr_sel;
  assign wr_en  = (st == S_RUN) && scl_rise && bitcnt == 4'd7 && idx >= FIRST_I && idx <= LAST_I;
  assign wr_sel = idx - FIRST_I;

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           q <= DEFAULTS[8*k +: 8];
      else if (wr_en && wr_sel == IW'(k))   q <= nxt;
    assign cfg_o[8*k +: 8] = q;
  end
endmodule

module cfg_serial_slave_chk #(
  parameter int NREG = 8,
  parameter int SKIP = 2,
  parameter logic [8*NREG-1:0] DEFAULTS = 64'h00FF0F5A00000381,
  parameter int IW = 4
) (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_pull_o,
  input logic [8*NREG-1:0] cfg_o,
  input logic [1:0] st,
  input logic [IW-1:0] idx
);
  AST_RESET_DEFAULTS: assert property (@(posedge clk) !rst_n |=> cfg_o == DEFAULTS); // R1
  AST_IDLE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n) st == 2'd0 |-> !sda_pull_o); // R2
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_pull_o) |-> !scl_s); // R9
  AST_SKIP_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n) st == 2'd2 |-> !sda_pull_o); // R4
  AST_WRITE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n) !$stable(cfg_o) |-> $past(st) == 2'd1); // R6
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n) 32'(idx) <= SKIP + NREG + 1); // R8
endmodule

bind cfg_serial_slave cfg_serial_slave_chk #(.NREG(NREG), .SKIP(SKIP), .DEFAULTS(DEFAULTS), .IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull_o(sda_pull_o),
  .cfg_o(cfg_o), .st(st), .idx(idx));

// File: tb/cfg_serial_slave_tb.sv
module cfg_serial_slave_tb_top;
  localparam int NREG = 8;
  localparam logic [63:0] DEF = 64'h00FF0F5A00000381;

  logic clk = 0, rst_n = 0, scl = 1, host_sda = 1;
  logic sda_pull;
  logic [63:0] cfg;
  wire sda_line = host_sda & ~sda_pull;

  always #5 clk = ~clk;

  cfg_serial_slave dut_i (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
                          .sda_pull_o(sda_pull), .cfg_o(cfg));

  int checks = 0, errors = 0;
  logic [7:0] exp_reg [NREG];
  bit exp_pull = 0;
  int settle = 4;
  string cur_req = "R1";
  bit m_active = 0;
  int m_pos = 0;

  function automatic logic [63:0] exp_flat();
    logic [63:0] v;
    for (int k = 0; k < NREG; k++) v[8*k +: 8] = exp_reg[k];
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n) begin
      if (settle > 0) settle--;
      else begin
        chk(cur_req, exp_flat(), cfg);
        chk("R9", 64'(exp_pull), 64'(sda_pull));
      end
    end
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl = 0; w(4); host_sda = 1; w(4); scl = 1; w(8);
    host_sda = 0; exp_pull = 0; settle = 4; m_active = 1; m_pos = 0; w(8);
    scl = 0; w(4);
  endtask

  task automatic bus_stop();
    scl = 0; w(4); host_sda = 0; w(4); scl = 1; w(8);
    host_sda = 1; exp_pull = 0; settle = 4; m_active = 0; w(8);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      host_sda = b[i]; w(4); scl = 1; w(8); scl = 0; w(4);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input string req);
    bit will_ack;
    bit data_pos;
    will_ack = m_active && ((m_pos == 0) ? (b == 8'hD2) : (m_pos <= 2 + NREG));
    data_pos = m_active && m_pos >= 3 && m_pos <= 2 + NREG;
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; w(4); scl = 1;
      if (i == 0 && data_pos) begin exp_reg[m_pos - 3] = b; settle = 4; end
      w(8); scl = 0;
      if (i == 0 && will_ack) begin exp_pull = 1; settle = 4; end
      w(4);
    end
    host_sda = 1; w(4); scl = 1; w(4);
    chk(req, 64'(sda_line), 64'(!will_ack));
    w(4); scl = 0; exp_pull = 0; settle = 4; w(4);
    if (will_ack) m_pos++; else m_active = 0;
  endtask

  task automatic full_write(input logic [7:0] a, input logic [7:0] c0, input logic [7:0] c1,
                            input logic [63:0] d, input string req);
    bus_start();
    send_byte(a, "R3");
    send_byte(c0, "R5");
    send_byte(c1, "R5");
    for (int k = 0; k < NREG; k++) send_byte(d[8*k +: 8], req);
    bus_stop();
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NREG; k++) exp_reg[k] = DEF[8*k +: 8];
    w(3);
    chk("R1", cfg, DEF);
    rst_n = 1; w(8);
    chk("R1", cfg, DEF);

    cur_req = "R6";
    full_write(8'hD2, 8'hA5, 8'h3C, 64'h8877665544332211, "R6");
    full_write(8'hD2, 8'h00, 8'hFF, 64'h01FE7F80C33CAA55, "R5");

    cur_req = "R4";
    bus_start(); send_byte(8'hD0, "R4");
    send_bits(8'h00, 8); send_bits(8'hFF, 8); bus_stop();
    bus_start(); send_byte(8'hD3, "R3");
    for (int k = 0; k < 4; k++) send_bits(8'h5A, 8);
    bus_stop();

    cur_req = "R7";
    bus_start(); send_byte(8'hD2, "R3"); send_byte(8'h11, "R5"); send_byte(8'h22, "R5");
    send_byte(8'hE1, "R7"); send_byte(8'hE2, "R7"); send_byte(8'hE3, "R7");
    bus_stop();
    bus_start(); send_byte(8'hD2, "R3"); send_byte(8'h11, "R5"); send_byte(8'h22, "R5");
    send_byte(8'h9C, "R7"); send_bits(8'h0F, 5);
    bus_stop();
    bus_start(); send_byte(8'hD2, "R3"); send_byte(8'h11, "R5"); send_byte(8'h22, "R5");
    send_byte(8'h4D, "R7");
    bus_start(); send_byte(8'hD2, "R2"); send_byte(8'h66, "R5"); send_byte(8'h77, "R5");
    send_byte(8'hB0, "R2"); send_byte(8'hB1, "R2");
    bus_stop();

    cur_req = "R8";
    bus_start(); send_byte(8'hD2, "R3"); send_byte(8'h01, "R5"); send_byte(8'h02, "R5");
    for (int k = 0; k < NREG; k++) send_byte(8'(8'h70 + k), "R6");
    send_byte(8'hEE, "R8"); send_byte(8'hDD, "R8");
    bus_stop();
    w(8);
    chk("R8", cfg, exp_flat());

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule